// File: doc/BRIEF.md
# Output Compare Pin Action Unit

This block drives eight timer output pins from eight compare channels. Each channel holds a compare value. On the clock edge where the shared free-running count equals that value, and the channel is set up as an output compare, the channel applies a programmed action to its own output latch. The action is one of: do nothing, toggle, force low or force high. Channel 7 is also a master channel. When channel 7 matches, it loads every pin whose master-mask bit is set from a master data byte. A set master-mask bit also stops that channel's own action.

Software sets up the block through a small register bus:

- two 8-bit action-control bytes;
- a master-mask byte;
- a master-data byte;
- an output-compare select byte;
- a sticky match-flag byte, cleared by writing ones;
- one compare register per channel.

A pin is taken over by the compare logic when its action code is nonzero or its master-mask bit is set. In that case the pin is driven from the latch and enabled as an output, whatever its data-direction bit says. Any other pin passes the port data bit through, with its output enable taken from the data-direction bit.

Top module: `oc_pin_unit`

## Requirements
- R1: After reset, all bus registers read zero, including the control bytes, compare registers and flags. All output latches are zero. Every pin then outputs its port data bit, with its output enable equal to its data-direction bit.
- R2: Bus addresses are: 0 = action control for channels 7..4, 1 = action control for channels 3..0, 2 = master mask, 3 = master data, 4 = output-compare select, 5 = match flags, 8+n = compare register of channel n. A write lands on the rising edge when the write strobe is high. Every register reads back combinationally at any time, with byte registers zero-extended.
- R3: Channel n's action code is bits {2n+1, 2n} of the 16-bit word {control 7..4, control 3..0}, with the mode bit above the level bit. So bit 7 of address 0 is channel 7's mode bit, and bit 0 of address 1 is channel 0's level bit.
- R4: A channel matches on a rising edge only when its select bit is 1 and the count input equals its compare register. With its select bit 0 it never matches, sets no flag and does not change its latch.
- R5: On a match with its master-mask bit clear, a channel updates its latch on that edge according to its action code: 00 leaves it, 01 inverts it, 10 clears it, 11 sets it.
- R6: A pin whose action code is nonzero, or whose master-mask bit is set, outputs its latch with output enable 1, regardless of its data-direction bit.
- R7: A pin whose action code is 00 and whose master-mask bit is clear outputs its port data bit, with output enable equal to its data-direction bit, even while its channel matches.
- R8: A set master-mask bit suppresses that channel's own action on its own match.
- R9: On a channel-7 match, every latch whose master-mask bit is set loads the matching bit of the master data byte.
- R10: When channel 7 and channel n match on the same edge and n's master-mask bit is set, n's latch takes the master data bit and not its own action result.
- R11: Each match sets that channel's flag, and the flag stays set. Writing 1 to a flag bit at address 5 clears it. A match on the same edge as the clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| count_i | input | 16 | Free-running timer count |
| port_d_i | input | 8 | Port data bits for pins not owned by the compare logic |
| port_ddr_i | input | 8 | Data-direction bits (1 = output) |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Pin output enables |

## Verification
Directed sequences on channel 0 step through all four action codes. The latch is preloaded so that toggle, clear and set each give a result that is visibly different from "no change". A code-00 match is then shown to leave a latch value that becomes visible again once the pin is reclaimed. Port data and direction patterns are chosen to differ from the latch value, so the data-direction override and the unowned pass-through can each be told apart from the compare path. Separate cases set up:
- a match with the select bit off;
- a master-masked own match;
- channel 7 and channel 0 matching on the same edge with opposing values;
- a flag clear on a matching edge.

These separate suppression, priority and set-wins-over-clear. A random phase with compare values and counts drawn from a small range makes matches frequent. It checks all pins and enables every cycle against a bench model.

// File: rtl/oc_pkg.sv
package oc_pkg;
   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_CLEAR  = 2'b10,
      ACT_SET    = 2'b11
   } oc_act_e;

   localparam int ADDR_CTL_HI = 0;
   localparam int ADDR_CTL_LO = 1;
   localparam int ADDR_MASK   = 2;
   localparam int ADDR_MDATA  = 3;
   localparam int ADDR_SEL    = 4;
   localparam int ADDR_FLAGS  = 5;
   localparam int ADDR_CMP    = 8;
endpackage

// File: rtl/oc_regs.sv
module oc_regs
   import oc_pkg::*;
#(
   parameter int NCH = 8,
   parameter int CW  = 16,
   parameter int AW  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_i,
   input  logic [AW-1:0]           addr_i,
   input  logic [CW-1:0]           wdata_i,
   input  logic [NCH-1:0]          match_i,
   output logic [2*NCH-1:0]        ctl_o,
   output logic [NCH-1:0]          mask_o,
   output logic [NCH-1:0]          mdata_o,
   output logic [NCH-1:0]          sel_o,
   output logic [NCH-1:0]          flags_o,
   output logic [NCH-1:0][CW-1:0]  cmp_o,
   output logic [CW-1:0]           rdata_o
);
   localparam int BYTE_W = 8;

   if (NCH != 8) begin : g_bad_nch
      $error("oc_regs: control layout needs exactly 8 channels");
   end
   if (CW < BYTE_W) begin : g_bad_cw
      $error("oc_regs: compare width below one byte");
   end
   if ((1 << AW) < ADDR_CMP + NCH) begin : g_bad_aw
      $error("oc_regs: address width too small for compare registers");
   end

   logic [BYTE_W-1:0] ctl_hi_q, ctl_lo_q;
   logic [NCH-1:0]    mask_q, mdata_q, sel_q, flags_q;

   function automatic logic hit(input logic [AW-1:0] a, input int target);
      return int'(a) == target;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_hi_q <= '0;
         ctl_lo_q <= '0;
         mask_q   <= '0;
         mdata_q  <= '0;
         sel_q    <= '0;
      end else if (wr_i) begin
         if (hit(addr_i, ADDR_CTL_HI)) ctl_hi_q <= wdata_i[BYTE_W-1:0];
         if (hit(addr_i, ADDR_CTL_LO)) ctl_lo_q <= wdata_i[BYTE_W-1:0];
         if (hit(addr_i, ADDR_MASK))   mask_q   <= wdata_i[NCH-1:0];
         if (hit(addr_i, ADDR_MDATA))  mdata_q  <= wdata_i[NCH-1:0];
         if (hit(addr_i, ADDR_SEL))    sel_q    <= wdata_i[NCH-1:0];
      end
   end

   logic [NCH-1:0] clr_w;
   assign clr_w = (wr_i && hit(addr_i, ADDR_FLAGS)) ? wdata_i[NCH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_w) | match_i;
   end

   for (genvar n = 0; n < NCH; n++) begin : g_cmp
      logic [CW-1:0] cmp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               cmp_q <= '0;
         else if (wr_i && hit(addr_i, ADDR_CMP + n)) cmp_q <= wdata_i;
      end
      assign cmp_o[n] = cmp_q;

      assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
         match_i[n] |=> flags_q[n])
         else $error("flag %0d not set after match", n);
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NCH; i++) begin
         if (hit(addr_i, ADDR_CMP + i)) rdata_o = cmp_o[i];
      end
      if (hit(addr_i, ADDR_CTL_HI)) rdata_o = CW'(ctl_hi_q);
      if (hit(addr_i, ADDR_CTL_LO)) rdata_o = CW'(ctl_lo_q);
      if (hit(addr_i, ADDR_MASK))   rdata_o = CW'(mask_q);
      if (hit(addr_i, ADDR_MDATA))  rdata_o = CW'(mdata_q);
      if (hit(addr_i, ADDR_SEL))    rdata_o = CW'(sel_q);
      if (hit(addr_i, ADDR_FLAGS))  rdata_o = CW'(flags_q);
   end

   assign ctl_o   = {ctl_hi_q, ctl_lo_q};
   assign mask_o  = mask_q;
   assign mdata_o = mdata_q;
   assign sel_o   = sel_q;
   assign flags_o = flags_q;
endmodule

// File: rtl/oc_channel.sv
module oc_channel
   import oc_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count_i,
   input  logic [CW-1:0] cmp_i,
   input  logic          sel_i,
   input  logic [1:0]    code_i,
   input  logic          mask_i,
   input  logic          m7_i,
   input  logic          mdata_i,
   input  logic          port_d_i,
   input  logic          ddr_i,
   output logic          match_o,
   output logic          pin_o,
   output logic          oe_o
);
   logic q_r;
   logic own_w;
   logic master_w;

   assign match_o  = sel_i && (count_i == cmp_i);
   assign master_w = m7_i && mask_i;
   assign own_w    = (code_i != ACT_NONE) || mask_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r <= 1'b0;
      end else if (master_w) begin
         q_r <= mdata_i;
      end else if (match_o && !mask_i) begin
         unique case (oc_act_e'(code_i))
            ACT_NONE:   q_r <= q_r;
            ACT_TOGGLE: q_r <= ~q_r;
            ACT_CLEAR:  q_r <= 1'b0;
            ACT_SET:    q_r <= 1'b1;
         endcase
      end
   end

   assign pin_o = own_w ? q_r  : port_d_i;
   assign oe_o  = own_w ? 1'b1 : ddr_i;

   assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && !mask_i && code_i == 2'b01) |=> (q_r != $past(q_r)))
      else $error("toggle action missed");
   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && !mask_i && code_i == 2'b10) |=> !q_r)
      else $error("clear action missed");
   assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && !mask_i && code_i == 2'b11) |=> q_r)
      else $error("set action missed");
   assert_mask_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_i && !m7_i) |=> $stable(q_r))
      else $error("masked channel changed without master match");
   assert_master_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (m7_i && mask_i) |=> (q_r == $past(mdata_i)))
      else $error("master load missed");
endmodule

// File: rtl/oc_pin_unit.sv
module oc_pin_unit
   import oc_pkg::*;
#(
   parameter int NCH = 8,
   parameter int CW  = 16,
   parameter int AW  = 4,
   parameter int MASTER_CH = NCH - 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_wr_i,
   input  logic [AW-1:0]  bus_addr_i,
   input  logic [CW-1:0]  bus_wdata_i,
   output logic [CW-1:0]  bus_rdata_o,
   input  logic [CW-1:0]  count_i,
   input  logic [NCH-1:0] port_d_i,
   input  logic [NCH-1:0] port_ddr_i,
   output logic [NCH-1:0] pin_o,
   output logic [NCH-1:0] pin_oe_o
);
   if (MASTER_CH < 0 || MASTER_CH >= NCH) begin : g_bad_master
      $error("oc_pin_unit: master channel out of range");
   end

   logic [2*NCH-1:0]       ctl_w;
   logic [NCH-1:0]         mask_w, mdata_w, sel_w, flags_w, match_w;
   logic [NCH-1:0][CW-1:0] cmp_w;
   logic                   m7_w;

   oc_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
      .match_i(match_w),
      .ctl_o(ctl_w), .mask_o(mask_w), .mdata_o(mdata_w), .sel_o(sel_w),
      .flags_o(flags_w), .cmp_o(cmp_w), .rdata_o(bus_rdata_o)
   );

   assign m7_w = match_w[MASTER_CH];

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      oc_channel #(.CW(CW)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .count_i(count_i), .cmp_i(cmp_w[n]), .sel_i(sel_w[n]),
         .code_i(ctl_w[2*n+1 -: 2]), .mask_i(mask_w[n]),
         .m7_i(m7_w), .mdata_i(mdata_w[n]),
         .port_d_i(port_d_i[n]), .ddr_i(port_ddr_i[n]),
         .match_o(match_w[n]), .pin_o(pin_o[n]), .oe_o(pin_oe_o[n])
      );

      assert_unselected_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!sel_w[n] && !(m7_w && mask_w[n]) && !$past(flags_w[n]) && !(bus_wr_i && int'(bus_addr_i) == ADDR_FLAGS))
            |=> !flags_w[n] || $past(flags_w[n]))
         else $error("unselected channel raised its flag");
   end
endmodule

// File: tb/oc_pin_unit_test.sv
module oc_pin_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [15:0] cnt = 16'hFFFF;
   logic [7:0]  pd = 8'hA5;
   logic [7:0]  ddr = 8'h0F;
   logic [7:0]  pin, oe;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   oc_pin_unit uut (
      .clk(clk), .rst_n(rst_n),
      .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .count_i(cnt), .port_d_i(pd), .port_ddr_i(ddr),
      .pin_o(pin), .pin_oe_o(oe)
   );

   always #5 clk = ~clk;

   // bench model of bus-visible state
   logic [15:0] m_ctl;
   logic [7:0]  m_mask, m_mdata, m_sel, m_flags, m_q;
   logic [15:0] m_cmp [8];

   function automatic logic [15:0] model_read(input logic [3:0] a);
      case (a)
         4'd0: return {8'h00, m_ctl[15:8]};
         4'd1: return {8'h00, m_ctl[7:0]};
         4'd2: return {8'h00, m_mask};
         4'd3: return {8'h00, m_mdata};
         4'd4: return {8'h00, m_sel};
         4'd5: return {8'h00, m_flags};
         default: return (a >= 4'd8) ? m_cmp[a - 4'd8] : 16'h0000;
      endcase
   endfunction

   function automatic logic [7:0] own_mask();
      logic [7:0] o;
      for (int n = 0; n < 8; n++) o[n] = (m_ctl[2*n+1 -: 2] != 2'b00) || m_mask[n];
      return o;
   endfunction

   function automatic logic [7:0] exp_pin();
      logic [7:0] o = own_mask();
      return (o & m_q) | (~o & pd);
   endfunction

   function automatic logic [7:0] exp_oe();
      return own_mask() | ddr;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_ctl = '0; m_mask = '0; m_mdata = '0; m_sel = '0; m_flags = '0; m_q = '0;
      for (int n = 0; n < 8; n++) m_cmp[n] = '0;
   endtask

   // one clock edge with the inputs as currently driven
   task automatic step(input string tag);
      logic [7:0] m, nq, nf;
      for (int n = 0; n < 8; n++) m[n] = m_sel[n] && (cnt == m_cmp[n]);
      nq = m_q;
      for (int n = 0; n < 8; n++) begin
         if (m[7] && m_mask[n]) nq[n] = m_mdata[n];
         else if (m[n] && !m_mask[n]) begin
            case (m_ctl[2*n+1 -: 2])
               2'b01: nq[n] = ~m_q[n];
               2'b10: nq[n] = 1'b0;
               2'b11: nq[n] = 1'b1;
               default: nq[n] = m_q[n];
            endcase
         end
      end
      nf = m_flags;
      if (wr && addr == 4'd5) nf = nf & ~wdata[7:0];
      nf = nf | m;
      @(posedge clk);
      @(negedge clk);
      m_q = nq;
      m_flags = nf;
      if (wr) begin
         case (addr)
            4'd0: m_ctl[15:8] = wdata[7:0];
            4'd1: m_ctl[7:0]  = wdata[7:0];
            4'd2: m_mask  = wdata[7:0];
            4'd3: m_mdata = wdata[7:0];
            4'd4: m_sel   = wdata[7:0];
            default: if (addr >= 4'd8) m_cmp[addr - 4'd8] = wdata;
         endcase
      end
      chk({tag, " pins"}, 32'(pin), 32'(exp_pin()));
      chk({tag, " enables"}, 32'(oe), 32'(exp_oe()));
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [15:0] d, input string tag);
      wr = 1'b1; addr = a; wdata = d;
      step(tag);
      wr = 1'b0;
   endtask

   task automatic match_at(input logic [15:0] c, input string tag);
      cnt = c;
      step(tag);
      cnt = 16'hFFFF;
   endtask

   task automatic rd_chk(input logic [3:0] a, input string tag);
      addr = a;
      #1;
      chk(tag, 32'(rdata), 32'(model_read(a)));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 reset pins follow port data", 32'(pin), 32'h000000A5);
      chk("R1 reset enables follow ddr", 32'(oe), 32'h0000000F);
      for (int a = 0; a < 16; a++) begin
         if (a == 6 || a == 7) continue;
         rd_chk(4'(a), "R1/R2 reset readback");
      end

      // R6, R3: low control byte, channel 0 toggle code
      wr_reg(4'd4, 16'h00FF, "R2 select write");
      wr_reg(4'd8, 16'h0010, "R2 compare write");
      wr_reg(4'd1, 16'h0001, "R3 ctl lo write");
      chk("R6 owned pin0 drives latch", 32'(pin[0]), 32'd0);
      chk("R6 owned pin0 enabled", 32'(oe[0]), 32'd1);
      chk("R3 channel 7 still unowned", 32'(oe[7]), 32'd0);

      // R5 toggle
      match_at(16'h0010, "R5 toggle");
      chk("R5 toggle to one", 32'(pin[0]), 32'd1);
      rd_chk(4'd5, "R11 flag after match");
      chk("R4 flag bit0 set", 32'(rdata[0]), 32'd1);
      match_at(16'h0010, "R5 toggle back");
      chk("R5 toggle to zero", 32'(pin[0]), 32'd0);

      // R5 set and clear
      wr_reg(4'd1, 16'h0003, "R3 set code");
      match_at(16'h0010, "R5 set");
      chk("R5 set drives one", 32'(pin[0]), 32'd1);
      wr_reg(4'd1, 16'h0002, "R3 clear code");
      match_at(16'h0010, "R5 clear");
      chk("R5 clear drives zero", 32'(pin[0]), 32'd0);

      // R5 none and R7 pass-through
      wr_reg(4'd1, 16'h0003, "R3 set code");
      match_at(16'h0010, "R5 set");
      pd = 8'hA4;
      wr_reg(4'd1, 16'h0000, "R7 release");
      chk("R7 released pin0 shows port data", 32'(pin[0]), 32'd0);
      match_at(16'h0010, "R7 idle match");
      chk("R7 idle match keeps port data", 32'(pin[0]), 32'd0);
      chk("R7 idle enable follows ddr", 32'(oe[0]), 32'd1);
      wr_reg(4'd1, 16'h0002, "R5 reclaim");
      chk("R5 code 00 left latch at one", 32'(pin[0]), 32'd1);
      pd = 8'hA5;

      // R4 select off
      wr_reg(4'd4, 16'h00FE, "R4 deselect");
      wr_reg(4'd5, 16'h00FF, "R11 clear all");
      match_at(16'h0010, "R4 no match");
      chk("R4 deselected latch unchanged", 32'(pin[0]), 32'd1);
      rd_chk(4'd5, "R4 flags");
      chk("R4 no flag when deselected", 32'(rdata[0]), 32'd0);
      wr_reg(4'd4, 16'h00FF, "R4 reselect");

      // R3 high byte: channel 7 codes
      wr_reg(4'd0, 16'h0080, "R3 ctl hi clear code");
      chk("R3 bit7 of hi byte owns pin7", 32'(oe[7]), 32'd1);
      wr_reg(4'd15, 16'h0020, "R2 cmp7 write");
      wr_reg(4'd0, 16'h00C0, "R3 ctl hi set code");
      match_at(16'h0020, "R3 ch7 set");
      chk("R3/R5 ch7 set", 32'(pin[7]), 32'd1);
      wr_reg(4'd0, 16'h0000, "R3 ctl hi off");

      // R8 mask suppress, R9 master load
      wr_reg(4'd1, 16'h0001, "R8 toggle code");
      wr_reg(4'd3, 16'h0000, "R9 mdata");
      wr_reg(4'd2, 16'h0001, "R8 mask");
      match_at(16'h0010, "R8 own match masked");
      chk("R8 masked own match no change", 32'(pin[0]), 32'd1);
      match_at(16'h0020, "R9 master");
      chk("R9 master loads pin0", 32'(pin[0]), 32'd0);
      chk("R7 pin7 unowned port data", 32'(pin[7]), 32'(pd[7]));
      wr_reg(4'd2, 16'h0003, "R6 mask owns pin1");
      chk("R6 mask-only pin1 enabled", 32'(oe[1]), 32'd1);
      wr_reg(4'd3, 16'h0003, "R9 mdata");
      match_at(16'h0020, "R9 master two pins");
      chk("R9 master loads pin0 and pin1", 32'(pin[1:0]), 32'd3);

      // R10 same-cycle priority
      wr_reg(4'd8, 16'h0030, "R10 cmp0");
      wr_reg(4'd15, 16'h0030, "R10 cmp7");
      wr_reg(4'd2, 16'h0001, "R10 mask");
      wr_reg(4'd3, 16'h0000, "R10 mdata");
      wr_reg(4'd1, 16'h0003, "R10 set code");
      match_at(16'h0030, "R10 both match");
      chk("R10 master value wins", 32'(pin[0]), 32'd0);

      // R11 clear on a matching edge
      cnt = 16'h0030;
      wr_reg(4'd5, 16'h0081, "R11 clear during match");
      cnt = 16'hFFFF;
      rd_chk(4'd5, "R11 flags");
      chk("R11 set wins over clear", 32'(rdata[7] & rdata[0]), 32'd1);
      wr_reg(4'd5, 16'h0081, "R11 clear idle");
      rd_chk(4'd5, "R11 flags");
      chk("R11 write-one clears", 32'(rdata[7] | rdata[0]), 32'd0);

      // random phase
      for (int i = 0; i < 600; i++) begin
         int pick;
         pick = $urandom % 14;
         pd  = 8'($urandom);
         ddr = 8'($urandom);
         cnt = 16'($urandom % 8);
         if (pick < 6) begin
            logic [3:0] a;
            a = (pick < 3) ? 4'(8 + ($urandom % 8)) : 4'($urandom % 6);
            wr = 1'b1; addr = a;
            wdata = (a >= 4'd8) ? 16'($urandom % 8) : 16'($urandom);
            step("R5/R6/R7/R9 random");
            wr = 1'b0;
         end else begin
            step("R5/R6/R7/R9 random");
         end
         if (i % 8 == 0) rd_chk(4'd5, "R11 random flags");
         if (i % 8 == 4) rd_chk(4'($urandom % 16), "R2 random readback");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule